// File: doc/BRIEF.md
# Multi-Port Reservation Monitor for Conditional Stores

This block sits between several requesting ports and a small word-addressed memory that it holds itself. Each port may ask for a plain read, a plain write, a reserving read or a conditional write. A reserving read returns the memory word and leaves a reservation on that word for the issuing port. A later conditional write from the same port to the same word succeeds only while that reservation is still intact. This lets software build atomic read-modify-write sequences without holding a lock.

The monitor serves at most one request per clock. The winner is the lowest-numbered port with a valid request, and the grant is given in the same cycle. The result appears one cycle later: a one-cycle response pulse on the winning port's bit, the read word on a shared data output, and a per-port pass/fail flag for conditional writes that holds its value until that port's next conditional write. A requester keeps its request asserted until it sees its grant bit.

Top module: `rsv_monitor`

## Requirements
- R1: After reset, all memory words read as zero, no port holds a reservation, and `grant`, `rspValid`, `rspData` and `scOk` are all zero.
- R2: A reserving read (op code 2) returns the addressed word on `rspData` and records a reservation for the issuing port on that address.
- R3: A conditional write (op code 3) succeeds only if the issuing port holds a reservation on exactly that address. On success it writes the word and sets that port's `scOk` bit to 1.
- R4: A conditional write that fails leaves memory unchanged and sets that port's `scOk` bit to 0.
- R5: Every conditional write, whether it passes or fails, removes the issuing port's own reservation, so a second conditional write without a fresh reserving read fails.
- R6: A successful conditional write removes every other port's reservation on the same address and leaves reservations on other addresses intact.
- R7: A plain write (op code 1) from any port writes memory and removes all reservations on that address.
- R8: Exactly one request is served per cycle. `grant` is one-hot, combinational, and selects the lowest-indexed port whose `reqValid` is high. If two conditional writes race for one reserved word, the lower port wins and the other fails when it is served later.
- R9: A new reserving read from a port replaces that port's earlier reservation, so a conditional write to the earlier address then fails.
- R10: A plain read (op code 0) returns the addressed word and changes no reservation.
- R11: The results of a request served in cycle t are visible in cycle t+1: `rspValid` pulses on the winner's bit; `rspData` carries the word for reads and is zero otherwise; a port's `scOk` bit keeps its value until that port's next conditional write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PORTS | Request present, one bit per port |
| reqOp | input | 2*NUM_PORTS | Per-port op code: 0 read, 1 write, 2 reserving read, 3 conditional write |
| reqAddr | input | ADDR_W*NUM_PORTS | Per-port word address |
| reqData | input | DATA_W*NUM_PORTS | Per-port write data |
| grant | output | NUM_PORTS | One-hot: the port served this cycle |
| rspValid | output | NUM_PORTS | One-cycle pulse on the port served in the previous cycle |
| rspData | output | DATA_W | Word read by the previous cycle's read or reserving read |
| scOk | output | NUM_PORTS | Result of each port's most recent conditional write |

## Verification
The assertions check every cycle that the grant is one-hot and never picks an idle port, that a reserving read installs the expected reservation, that every conditional write leaves its own port unreserved, and that after a plain write or a successful conditional write no port still holds a reservation on that address. Whether a conditional write passes or fails depends on the history of requests across ports. That is shown only by the bench scenarios, compared against a behavioural model: write races, replaced reservations, and a plain write cutting into another port's read-modify-write sequence.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LR    = 2'd2,
    OP_SC    = 2'd3
  } memOp_e;

  typedef struct packed {
    logic act;
    logic rdEn;
    logic memWr;
    logic setRsv;
    logic clrOwn;
    logic clrMatch;
    logic scUpd;
    logic scPass;
  } ctrlStrb_t;

endpackage

// File: rtl/rsv_arbiter.sv
module rsv_arbiter #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          reqValid,
  input  logic [2*NUM_PORTS-1:0]        reqOp,
  input  logic [ADDR_W*NUM_PORTS-1:0]   reqAddr,
  input  logic [DATA_W*NUM_PORTS-1:0]   reqData,
  output logic [NUM_PORTS-1:0]          grant,
  output logic [IDX_W-1:0]              winIdx,
  output logic                          anyReq,
  output rsv_pkg::memOp_e               selOp,
  output logic [ADDR_W-1:0]             selAddr,
  output logic [DATA_W-1:0]             selData
);
  import rsv_pkg::*;

  always_comb begin
    winIdx = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (reqValid[p]) winIdx = IDX_W'(p);
    end
  end

  assign anyReq = |reqValid;

  always_comb begin
    grant = '0;
    if (anyReq) grant[winIdx] = 1'b1;
  end

  assign selOp   = memOp_e'(reqOp[winIdx*2 +: 2]);
  assign selAddr = reqAddr[winIdx*ADDR_W +: ADDR_W];
  assign selData = reqData[winIdx*DATA_W +: DATA_W];

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R8
  AST_GRANT_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~reqValid) == '0); // R8
  AST_NO_IDLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|reqValid) |-> (|grant)); // R8

endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl (
  input  logic                  anyReq,
  input  rsv_pkg::memOp_e       selOp,
  input  logic                  rsvHit,
  output rsv_pkg::ctrlStrb_t    strb
);
  import rsv_pkg::*;

  always_comb begin
    strb = '0;
    if (anyReq) begin
      strb.act = 1'b1;
      unique case (selOp)
        OP_LOAD: begin
          strb.rdEn = 1'b1;
        end
        OP_STORE: begin
          strb.memWr    = 1'b1;
          strb.clrMatch = 1'b1;
        end
        OP_LR: begin
          strb.rdEn   = 1'b1;
          strb.setRsv = 1'b1;
        end
        OP_SC: begin
          strb.scUpd  = 1'b1;
          strb.clrOwn = 1'b1;
          if (rsvHit) begin
            strb.scPass   = 1'b1;
            strb.memWr    = 1'b1;
            strb.clrMatch = 1'b1;
          end
        end
        default: strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/rsv_datapath.sv
module rsv_datapath #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  rsv_pkg::ctrlStrb_t    strb,
  input  logic [IDX_W-1:0]      winIdx,
  input  logic [ADDR_W-1:0]     selAddr,
  input  logic [DATA_W-1:0]     selData,
  output logic                  rsvHit,
  output logic [NUM_PORTS-1:0]  rspValid,
  output logic [DATA_W-1:0]     rspData,
  output logic [NUM_PORTS-1:0]  scOk
);
  import rsv_pkg::*;

  logic [DATA_W-1:0]    mem [DEPTH];
  logic [NUM_PORTS-1:0] rsvValid;
  logic [ADDR_W-1:0]    rsvAddr [NUM_PORTS];
  logic [NUM_PORTS-1:0] addrMatch;

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_match
      assign addrMatch[gp] = rsvValid[gp] && (rsvAddr[gp] == selAddr);

      AST_NO_SURVIVOR: assert property (@(posedge clk) disable iff (!rst_n)
        strb.clrMatch |=> !(rsvValid[gp] && (rsvAddr[gp] == $past(selAddr)))); // R6 R7
    end
  endgenerate

  assign rsvHit = addrMatch[winIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int p = 0; p < NUM_PORTS; p++) rsvAddr[p] <= '0;
      rsvValid <= '0;
      rspValid <= '0;
      rspData  <= '0;
      scOk     <= '0;
    end else begin
      rspValid <= '0;
      if (strb.act) rspValid[winIdx] <= 1'b1;
      rspData <= strb.rdEn ? mem[selAddr] : '0;
      if (strb.memWr) mem[selAddr] <= selData;
      if (strb.scUpd) scOk[winIdx] <= strb.scPass;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strb.clrMatch && addrMatch[p]) rsvValid[p] <= 1'b0;
      end
      if (strb.clrOwn) rsvValid[winIdx] <= 1'b0;
      if (strb.setRsv) begin
        rsvValid[winIdx] <= 1'b1;
        rsvAddr[winIdx]  <= selAddr;
      end
    end
  end

  AST_LR_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
    strb.setRsv |=> (rsvValid[$past(winIdx)] &&
                     (rsvAddr[$past(winIdx)] == $past(selAddr)))); // R2
  AST_SC_DROPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrOwn |=> !rsvValid[$past(winIdx)]); // R5
  AST_PASS_HAD_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    strb.scPass |-> (rsvValid[winIdx] && (rsvAddr[winIdx] == selAddr))); // R3
  AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rspValid)); // R11

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [2*NUM_PORTS-1:0]      reqOp,
  input  logic [ADDR_W*NUM_PORTS-1:0] reqAddr,
  input  logic [DATA_W*NUM_PORTS-1:0] reqData,
  output logic [NUM_PORTS-1:0]        grant,
  output logic [NUM_PORTS-1:0]        rspValid,
  output logic [DATA_W-1:0]           rspData,
  output logic [NUM_PORTS-1:0]        scOk
);
  import rsv_pkg::*;

  logic [IDX_W-1:0]  winIdx;
  logic              anyReq;
  memOp_e            selOp;
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;
  logic              rsvHit;
  ctrlStrb_t         strb;

  rsv_arbiter #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .grant(grant), .winIdx(winIdx),
    .anyReq(anyReq), .selOp(selOp), .selAddr(selAddr), .selData(selData)
  );

  rsv_ctrl u_ctrl (
    .anyReq(anyReq), .selOp(selOp), .rsvHit(rsvHit), .strb(strb)
  );

  rsv_datapath #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .winIdx(winIdx), .selAddr(selAddr),
    .selData(selData), .rsvHit(rsvHit), .rspValid(rspValid), .rspData(rspData),
    .scOk(scOk)
  );

endmodule

// File: tb/rsv_monitor_tb.sv
module rsv_monitor_tb;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    reqValid;
  logic [2*N-1:0]  reqOp;
  logic [AW*N-1:0] reqAddr;
  logic [DW*N-1:0] reqData;
  logic [N-1:0]    grant;
  logic [N-1:0]    rspValid;
  logic [DW-1:0]   rspData;
  logic [N-1:0]    scOk;

  always #4 clk = ~clk;

  rsv_monitor #(.NUM_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .grant(grant),
    .rspValid(rspValid), .rspData(rspData), .scOk(scOk)
  );

  logic          bV [N];
  logic [1:0]    bOp [N];
  logic [AW-1:0] bA [N];
  logic [DW-1:0] bD [N];

  always_comb begin
    for (int p = 0; p < N; p++) begin
      reqValid[p]          = bV[p];
      reqOp[p*2 +: 2]      = bOp[p];
      reqAddr[p*AW +: AW]  = bA[p];
      reqData[p*DW +: DW]  = bD[p];
    end
  end

  // behavioural reference state
  logic [DW-1:0] mMem [DEPTH];
  logic          mRv [N];
  logic [AW-1:0] mRa [N];
  logic [N-1:0]  mOk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clearReq();
    for (int p = 0; p < N; p++) begin
      bV[p] = 1'b0; bOp[p] = 2'd0; bA[p] = '0; bD[p] = '0;
    end
  endtask

  task automatic req(int p, int op, int a, int d);
    bV[p] = 1'b1; bOp[p] = 2'(op); bA[p] = AW'(a); bD[p] = DW'(d);
  endtask

  // one cycle: inputs already set at a negedge
  task automatic step(string tag);
    int w;
    logic [N-1:0] expG;
    logic [N-1:0] expRv;
    logic [DW-1:0] expD;
    logic pass;
    logic [AW-1:0] a;
    w = -1;
    for (int p = N - 1; p >= 0; p--) if (bV[p]) w = p;
    expG = '0; expRv = '0; expD = '0;
    if (w >= 0) begin
      expG[w] = 1'b1;
      expRv[w] = 1'b1;
      a = bA[w];
      case (bOp[w])
        2'd0: expD = mMem[a];
        2'd1: begin
          mMem[a] = bD[w];
          for (int p = 0; p < N; p++) if (mRv[p] && mRa[p] == a) mRv[p] = 1'b0;
        end
        2'd2: begin
          expD = mMem[a]; mRv[w] = 1'b1; mRa[w] = a;
        end
        default: begin
          pass = mRv[w] && (mRa[w] == a);
          mRv[w] = 1'b0;
          if (pass) begin
            mMem[a] = bD[w];
            for (int p = 0; p < N; p++) if (mRv[p] && mRa[p] == a) mRv[p] = 1'b0;
          end
          mOk[w] = pass;
        end
      endcase
    end
    #1;
    check("R8", "grant", grant, expG);
    @(posedge clk);
    @(negedge clk);
    clearReq();
    check(tag, "rspValid", rspValid, expRv);
    check(tag, "rspData", rspData, expD);
    check(tag, "scOk", scOk, mOk);
  endtask

  task automatic one(string tag, int p, int op, int a, int d);
    req(p, op, a, d);
    step(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clearReq();
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    for (int p = 0; p < N; p++) begin mRv[p] = 1'b0; mRa[p] = '0; end
    mOk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "grant", grant, 0);
    check("R1", "rspValid", rspValid, 0);
    check("R1", "rspData", rspData, 0);
    check("R1", "scOk", scOk, 0);
    one("R1", 0, 0, 5, 0);
    one("R1", 1, 3, 5, 16'h1111);          // no reservation after reset -> fail
    // R2 / R3 reserving read then pass
    one("R2", 1, 2, 3, 0);
    one("R3", 1, 3, 3, 16'hAAAA);
    one("R3", 0, 0, 3, 0);
    // R4 failures
    one("R4", 2, 3, 4, 16'h4444);
    one("R4", 2, 0, 4, 0);
    one("R4", 2, 2, 4, 0);
    one("R4", 2, 3, 5, 16'h5555);
    one("R4", 2, 0, 5, 0);
    // R5 own reservation dropped
    one("R5", 0, 2, 6, 0);
    one("R5", 0, 3, 6, 16'h6666);
    one("R5", 0, 3, 6, 16'h6767);
    one("R5", 0, 0, 6, 0);
    // R6 cross-port cancel
    one("R6", 0, 2, 7, 0);
    one("R6", 1, 2, 7, 0);
    one("R6", 2, 2, 8, 0);
    one("R6", 1, 3, 7, 16'h7777);
    one("R6", 0, 3, 7, 16'h7070);
    one("R6", 2, 3, 8, 16'h8888);
    one("R6", 3, 0, 7, 0);
    // R7 plain write cancels
    one("R7", 3, 2, 9, 0);
    one("R7", 0, 1, 9, 16'h9999);
    one("R7", 3, 3, 9, 16'h9090);
    one("R7", 3, 0, 9, 0);
    // R8 same-cycle priority and race
    req(1, 2, 10, 0); req(2, 2, 10, 0); step("R8");
    one("R8", 2, 2, 10, 0);
    one("R8", 0, 2, 11, 0);
    one("R8", 1, 2, 11, 0);
    req(0, 3, 11, 16'hB0B0); req(1, 3, 11, 16'hB1B1); req(3, 0, 11, 0); step("R8");
    req(1, 3, 11, 16'hB1B1); req(3, 0, 11, 0); step("R8");
    one("R8", 3, 0, 11, 0);
    // R9 replacement
    one("R9", 2, 2, 12, 0);
    one("R9", 2, 2, 13, 0);
    one("R9", 2, 3, 12, 16'hCCCC);
    one("R9", 2, 2, 13, 0);
    one("R9", 2, 3, 13, 16'hDDDD);
    // R10 plain read leaves reservation
    one("R10", 3, 2, 14, 0);
    one("R10", 0, 0, 14, 0);
    one("R10", 3, 0, 14, 0);
    one("R10", 3, 3, 14, 16'hEEEE);
    // R11 scOk holds, idle cycle gives no pulse
    one("R11", 0, 0, 1, 0);
    one("R11", 1, 1, 2, 16'h0202);
    step("R11");
    // random traffic on few addresses
    for (int k = 0; k < 3000; k++) begin
      for (int p = 0; p < N; p++) begin
        if ($urandom_range(0, 2) != 0) req(p, $urandom_range(0, 3), $urandom_range(0, 3), $urandom);
      end
      step("R6 R7 random");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule